// File: doc/BRIEF.md
# Down-Counting PWM Generator with Buffered Duty Level

This block drives one pin with a pulse-width-modulated waveform. Time is measured in count steps, and each step lasts a fixed number of system clocks (three by default). A period of `P` holds `P+1` steps. During those steps a down-counter walks from `P` to zero. The pin is low at the start of each period. It goes high in the step where the counter equals the current duty level and stays high until the period ends.

The host sets the period through a configuration write, which the block takes only while it is disabled and idle. Duty levels go into a four-entry buffer. At the start of every period the block takes one level from the buffer if one is waiting, and otherwise keeps the level it already holds, so the period never stalls on the host. A polarity input inverts the pin after the waveform logic. Deasserting enable forces the pin to its idle level.

Top module: `pwm_dcount`

## Requirements
- R1: After reset the held period and held level are both zero, the buffer is empty (`lvl_full` low) and the pin is low when `invert` is low. Enabling with no further writes therefore gives one-step periods with the pin high throughout.
- R2: Once running, one period lasts exactly 3*(P+1) clocks, where P is the held period. Every step lasts 3 clocks.
- R3: In the clock after enable is sampled low, `pwm_out` equals `invert`, which is the inactive level (low before inversion).
- R4: In each period with held level L, the pin (before inversion) is low for the steps whose counter is above L and high for the steps whose counter is at or below L. With L > P it is low for the whole period.
- R5: At the start of every period one level is taken from the buffer. If the buffer is empty, the previous level is reused.
- R6: A period write (`cfg_wr`) takes effect only if enable was low and the block was idle. A write made while the block runs is ignored.
- R7: With `invert` high the pin is the bitwise complement of the waveform, and the count timing is unchanged.
- R8: The level buffer holds 4 entries in write order. `lvl_full` rises in the clock after the fourth unread write, and a write while full is dropped.
- R9: On the edge that samples enable high, a fresh period starts: the counter loads P and the first step shows counter P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run the waveform when high |
| invert | input | 1 | Complement the pin output |
| cfg_wr | input | 1 | Period write strobe |
| cfg_period | input | CNT_W | Period value in steps (period lasts value+1 steps) |
| lvl_wr | input | 1 | Duty level write strobe |
| lvl_data | input | CNT_W | Duty level in steps |
| lvl_full | output | 1 | Level buffer is full |
| pwm_out | output | 1 | PWM pin |

## Verification
The edge that samples enable high starts the period, and the pin shows the first step from the next falling edge on. Each later step boundary falls exactly 3 clocks after the one before, and a period boundary falls 3*(P+1) clocks after the one before. The bench counts falling edges from the enabling edge and works out step index, counter value and the level in use for each sample by arithmetic. It compares every sample of whole periods against that. `lvl_full` is due one clock after the fourth write, and the idle pin level is due one clock after enable falls, so both are sampled at the falling edge that follows.

// File: rtl/pwm_pkg.sv
// Package: shared defaults for the down-counting PWM generator.
// Assumes: consumers take these as parameter defaults only.
package pwm_pkg;
    localparam int unsigned PWM_DEF_CNT_W = 8;  // counter / level width
    localparam int unsigned PWM_DEF_TICK  = 3;  // clocks per count step
    localparam int unsigned PWM_DEF_DEPTH = 4;  // level buffer entries
endpackage

// File: rtl/pwm_lvl_fifo.sv
// Module: small level buffer, first in first out, with full/empty flags.
// Assumes: pushes while full are dropped; pops while empty are ignored.
module pwm_lvl_fifo #(
    parameter int unsigned W     = pwm_pkg::PWM_DEF_CNT_W,
    parameter int unsigned DEPTH = pwm_pkg::PWM_DEF_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_ptr_q, rd_ptr_q;
    logic [CW-1:0] fill_q;
    logic          push_ok, pop_ok;

    assign empty   = (fill_q == '0);
    assign full    = (fill_q == CW'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign dout    = mem_q[rd_ptr_q];

    // Store accepted entries at the write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (push_ok) begin
            mem_q[wr_ptr_q] <= din;
        end
    end

    // Advance pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            if (push_ok)
                wr_ptr_q <= (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
            if (pop_ok)
                rd_ptr_q <= (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
            if (push_ok && !pop_ok)      fill_q <= fill_q + 1'b1;
            else if (pop_ok && !push_ok) fill_q <= fill_q - 1'b1;
        end
    end
endmodule

// File: rtl/pwm_step_timer.sv
// Module: divides the clock into count steps of TICK clocks each.
// Assumes: step_end pulses on the last clock of each step while run is high;
//          the phase restarts from zero whenever run is low.
module pwm_step_timer #(
    parameter int unsigned TICK = pwm_pkg::PWM_DEF_TICK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_end
);
    generate
        if (TICK <= 1) begin : g_single
            assign step_end = run;
        end else begin : g_phase
            localparam int unsigned PW = $clog2(TICK);
            logic [PW-1:0] phase_q;

            assign step_end = run && (phase_q == PW'(TICK - 1));

            // Count clocks within a step; hold at zero while idle.
            always_ff @(posedge clk) begin
                if (!rst_n || !run) phase_q <= '0;
                else if (step_end)  phase_q <= '0;
                else                phase_q <= phase_q + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/pwm_wave_core.sv
// Module: period register, down-counter, held level and sticky high flag.
// Assumes: step_end comes from a timer gated by running; the level source
//          is popped without waiting at each period start.
module pwm_wave_core #(
    parameter int unsigned CNT_W = pwm_pkg::PWM_DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             step_end,
    input  logic             src_empty,
    input  logic [CNT_W-1:0] src_level,
    output logic             src_pop,
    output logic             running,
    output logic             hi,
    output logic             wrap,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per
);
    logic [CNT_W-1:0] per_q, cnt_q, lvl_q, next_lvl, cnt_dec;
    logic             run_q, hi_q, start_now, wrap_now, begin_period;

    assign start_now    = enable && !run_q;
    assign wrap_now     = enable && run_q && step_end && (cnt_q == '0);
    assign begin_period = start_now || wrap_now;
    assign src_pop      = begin_period && !src_empty;
    assign next_lvl     = src_empty ? lvl_q : src_level;
    assign cnt_dec      = cnt_q - 1'b1;

    assign running = run_q;
    assign hi      = hi_q;
    assign wrap    = wrap_now;
    assign cnt     = cnt_q;
    assign per     = per_q;

    // Period register: writable only while disabled and idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                              per_q <= '0;
        else if (cfg_wr && !enable && !run_q)    per_q <= cfg_period;
    end

    // Run flag follows enable one clock later.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= enable;
    end

    // Counter, held level and sticky high flag per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= '0;
            hi_q  <= 1'b0;
        end else if (!enable) begin
            hi_q  <= 1'b0;
        end else if (begin_period) begin
            cnt_q <= per_q;
            lvl_q <= next_lvl;
            hi_q  <= (per_q == next_lvl);
        end else if (step_end) begin
            cnt_q <= cnt_dec;
            if (cnt_dec == lvl_q) hi_q <= 1'b1;
        end
    end
endmodule

// File: rtl/pwm_dcount.sv
// Module: top of the down-counting PWM generator with buffered duty level.
// Assumes: host writes period only while disabled; polarity is applied at
//          the pin after the waveform logic.
module pwm_dcount #(
    parameter int unsigned CNT_W = pwm_pkg::PWM_DEF_CNT_W,
    parameter int unsigned TICK  = pwm_pkg::PWM_DEF_TICK,
    parameter int unsigned DEPTH = pwm_pkg::PWM_DEF_DEPTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             invert,
    input  logic             cfg_wr,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic             lvl_wr,
    input  logic [CNT_W-1:0] lvl_data,
    output logic             lvl_full,
    output logic             pwm_out
);
    logic             fifo_pop, fifo_empty, step_end, running, hi, wrap;
    logic [CNT_W-1:0] fifo_dout, cnt, per;

    pwm_lvl_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(lvl_wr), .din(lvl_data),
        .pop(fifo_pop), .dout(fifo_dout), .empty(fifo_empty), .full(lvl_full)
    );

    pwm_step_timer #(.TICK(TICK)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(running), .step_end(step_end)
    );

    pwm_wave_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
        .cfg_period(cfg_period), .step_end(step_end), .src_empty(fifo_empty),
        .src_level(fifo_dout), .src_pop(fifo_pop), .running(running),
        .hi(hi), .wrap(wrap), .cnt(cnt), .per(per)
    );

    // Pin: idle low while stopped, then optional inversion.
    assign pwm_out = (running && hi) ^ invert;
endmodule

// File: rtl/pwm_dcount_checker.sv
// Module: assertion checker for pwm_dcount, attached by bind.
// Assumes: connected to the top's ports and its inter-module nets.
module pwm_dcount_checker #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             invert,
    input logic             lvl_wr,
    input logic             lvl_full,
    input logic             pwm_out,
    input logic             running,
    input logic             hi,
    input logic             wrap,
    input logic             fifo_pop,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per
);
    // R3: pin sits at the inactive level one clock after enable is low.
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (pwm_out == invert));

    // R6: period register cannot move while the block runs.
    a_r6_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
        running |=> $stable(per));

    // R2: counter reloads the held period at each wrap.
    a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == $past(per)));

    // R4: once high, the waveform stays high until the period ends.
    a_r4_high_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hi && !wrap) |=> hi);

    // R8: a write into a full buffer without a pop leaves it full.
    a_r8_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_full && lvl_wr && !fifo_pop) |=> lvl_full);
endmodule

bind pwm_dcount pwm_dcount_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
    .lvl_wr(lvl_wr), .lvl_full(lvl_full), .pwm_out(pwm_out),
    .running(running), .hi(hi), .wrap(wrap), .fifo_pop(fifo_pop),
    .cnt(cnt), .per(per)
);

// File: tb/pwm_dcount_test.sv
// Bench: sweeps small periods and levels, computing the pin per clock.
module pwm_dcount_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         invert = 1'b0;
    logic         cfg_wr = 1'b0;
    logic [W-1:0] cfg_period = '0;
    logic         lvl_wr = 1'b0;
    logic [W-1:0] lvl_data = '0;
    logic         lvl_full;
    logic         pwm_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pwm_dcount uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
        .cfg_wr(cfg_wr), .cfg_period(cfg_period), .lvl_wr(lvl_wr),
        .lvl_data(lvl_data), .lvl_full(lvl_full), .pwm_out(pwm_out)
    );

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic push(input int v);
        @(negedge clk); lvl_wr = 1'b1; lvl_data = W'(v);
        @(negedge clk); lvl_wr = 1'b0;
    endtask

    task automatic set_period(input int p);
        @(negedge clk); cfg_wr = 1'b1; cfg_period = W'(p);
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk); enable = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Enable, then compare every sample of nper periods with the model.
    task automatic run_check(input string req, input int p, input int nper,
                             input int lv[8]);
        int bad = 0, first_t = -1, first_got = 0, first_exp = 0;
        int plen = 3 * (p + 1);
        @(negedge clk); enable = 1'b1;
        for (int t = 0; t < nper * plen; t++) begin
            int pi, step, c, lvl, e;
            @(negedge clk);
            pi   = t / plen;
            step = (t / 3) % (p + 1);
            c    = p - step;
            lvl  = lv[pi];
            e    = ((lvl <= p) && (c <= lvl)) ? 1 : 0;
            e    = e ^ int'(invert);
            if (int'(pwm_out) != e) begin
                if (bad == 0) begin first_t = t; first_got = int'(pwm_out); first_exp = e; end
                bad++;
            end
        end
        n_tests++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: P=%0d at sample %0d got %0d expected %0d (%0d bad)",
                     req, p, first_t, first_got, first_exp, bad);
        end
        stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int lv[8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 pin after reset", int'(pwm_out), 0);
        check("R1 full after reset", int'(lvl_full), 0);
        // R1: zero period and zero level give a constantly high pin
        foreach (lv[i]) lv[i] = 0;
        run_check("R1 zero period/level", 0, 4, lv);

        // R2 R4 R5 R9: sweep period and level; second period reuses level
        for (int p = 0; p <= 5; p++) begin
            for (int l = 0; l <= 6; l++) begin
                set_period(p);
                push(l);
                foreach (lv[i]) lv[i] = l;
                run_check("R2/R4/R5/R9 sweep", p, 2, lv);
            end
        end

        // R3: idle level follows invert
        check("R3 idle low", int'(pwm_out), 0);
        @(negedge clk); invert = 1'b1;
        @(negedge clk);
        check("R3 idle inverted", int'(pwm_out), 1);

        // R7: inverted waveform keeps timing
        set_period(4);
        push(2);
        foreach (lv[i]) lv[i] = 2;
        run_check("R7 inverted", 4, 2, lv);
        check("R3 idle after inverted run", int'(pwm_out), 1);
        @(negedge clk); invert = 1'b0;

        // R6: period write while running is ignored
        set_period(3);
        push(1);
        @(negedge clk); enable = 1'b1;
        repeat (2) @(negedge clk);
        cfg_wr = 1'b1; cfg_period = W'(6);
        @(negedge clk); cfg_wr = 1'b0;
        stop();
        push(2);
        foreach (lv[i]) lv[i] = 2;
        run_check("R6 write ignored while running", 3, 2, lv);

        // R8: four entries fill the buffer; the fifth write is dropped
        set_period(2);
        push(1); push(2); push(3);
        check("R8 not full at three", int'(lvl_full), 0);
        push(4);
        check("R8 full at four", int'(lvl_full), 1);
        push(0);
        check("R8 still full after drop", int'(lvl_full), 1);
        lv[0] = 1; lv[1] = 2; lv[2] = 3; lv[3] = 4; lv[4] = 4; lv[5] = 4;
        lv[6] = 4; lv[7] = 4;
        run_check("R8/R5 buffered order and drop", 2, 6, lv);
        check("R8 empty after drain", int'(lvl_full), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule